// File: doc/BRIEF.md
# EDID Serial Transmitter for a Sync-Clocked Display Link

This block sends display identification bytes out over one serial data line on a transmit-only, point-to-point link. The clock of the link is the display's vertical sync pulse train. That clock is external and slow, running at up to 25 kHz. The block brings it into the fast system clock domain through a two-stage synchronizer. It reacts to the rising edges of that clock only. The data line is open-drain in style: the block drives a data value together with an output enable, and a deasserted enable means the line is released to high impedance. The block has no input from the data line and never reads it.

When the link is switched on, the first nine clock periods form a synchronization preamble, and the line stays released for all of them. After that, the bytes follow back to back. Each byte takes a nine-slot frame. Slots one to eight carry the bits, most significant bit first. In slot nine the line is released and a one-cycle byte-done interrupt is raised. Each byte is read from a 256-entry byte buffer at the address held in a transmit pointer. The pointer steps forward by one per byte. It wraps to zero at the end of the chosen region, which is either 128 or 256 bytes, so the table repeats for as long as the clock runs.

The processor side has a software-access bit. While this bit is set, the processor may write and read the buffer and load the transmit pointer. While it is clear, the region used for transmission is locked. In 128-byte mode the upper half of the buffer stays open for plain reads and writes, and the pointer never steps into that half.

Top module: `edid_serial_tx`

## Requirements
- R1: After reset, `sda_oe` is 0, `byte_irq` is 0, `tx_ptr` is 0 and `cpu_rdata` is 0.
- R2: After `link_en` rises, the first 9 rising edges of `vclk_in` keep `sda_oe` at 0 and raise no `byte_irq`.
- R3: After the preamble, frame slots 1 to 8 drive `sda_oe` high. Slot k drives bit (8-k) of the byte at the pointer value held when slot 1 began, so the most significant bit goes first.
- R4: In slot 9 `sda_oe` returns to 0 and `byte_irq` is high for exactly one system clock cycle. This gives exactly one pulse per frame.
- R5: With `size_full`=0 the pointer runs through 0..127. From 127 (or any higher value) it wraps to 0.
- R6: With `size_full`=1 the pointer runs through 0..255 and wraps from 255 to 0.
- R7: The pointer advances once per byte, at the start of slot 1. Otherwise it holds, except when `ptr_we` is high with `sw_access`=1, which loads `ptr_wdata`.
- R8: With `sw_access`=0, writes, reads and pointer loads are ignored for the active region. With `size_full`=0, addresses 128..255 (bit 7 set) can still be written and read.
- R9: When `link_en` goes low, `sda_oe` is 0 one system clock later and the frame position is cleared. When it is enabled again, the preamble of R2 repeats and then sending resumes at the current pointer.
- R10: A rising edge on `vclk_in` changes the outputs on the third system clock edge after it. A falling edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vclk_in | input | 1 | Link clock (vertical sync), asynchronous |
| link_en | input | 1 | Enables transmission; low holds the link idle |
| sw_access | input | 1 | Software access to buffer and pointer |
| size_full | input | 1 | 0 selects the 128-byte region, 1 selects 256 bytes |
| cpu_we | input | 1 | Buffer write strobe |
| cpu_addr | input | 8 | Buffer address for processor access |
| cpu_wdata | input | 8 | Buffer write data |
| cpu_rdata | output | 8 | Registered buffer read data (one cycle latency) |
| ptr_we | input | 1 | Transmit pointer load strobe |
| ptr_wdata | input | 8 | Transmit pointer load value |
| tx_ptr | output | 8 | Current transmit pointer |
| sda_o | output | 1 | Serial data value (1 while released) |
| sda_oe | output | 1 | Data drive enable; 0 means high impedance |
| byte_irq | output | 1 | One-cycle pulse in slot 9 of each frame |

## Verification
The buffer is filled with an arithmetic pattern in which neighbouring bytes differ in many bit positions. This means an error in bit order, slot order or byte selection shows up as a wrong bit. Each slot of every frame is checked on three things: the enable, the bit and the interrupt count. This is done over more than a full pass of the 128-byte region and then of the 256-byte region, so the two wrap points and the locked upper half are told apart. One rising edge is sampled cycle by cycle to pin the synchronizer latency, and the falling edge that follows must leave the outputs unchanged. A disable in the middle of a frame, followed by an enable, must bring back the full preamble. The locked and open address ranges are written with software access off and then read back with it on.

// File: rtl/edid_tx_pkg.sv
package edid_tx_pkg;

  localparam int unsigned EDID_AW = 8;
  localparam int unsigned EDID_DW = 8;
  localparam int unsigned FRAME_SLOTS = EDID_DW + 1;
  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS + 1);

  typedef logic [EDID_AW-1:0] edid_addr_t;
  typedef logic [EDID_DW-1:0] edid_byte_t;
  typedef logic [SLOT_W-1:0]  slot_t;

  typedef enum logic {
    LNK_PREAMBLE = 1'b0,
    LNK_FRAMES   = 1'b1
  } link_state_e;

  // Highest pointer value inside the active region.
  function automatic edid_addr_t region_last(input logic full);
    edid_addr_t all_ones;
    edid_addr_t half_ones;
    all_ones  = '1;
    half_ones = {1'b0, {(EDID_AW-1){1'b1}}};
    return full ? all_ones : half_ones;
  endfunction

  // Pointer value after one byte has been fetched.
  function automatic edid_addr_t ptr_advance(input edid_addr_t p, input logic full);
    edid_addr_t nxt;
    if (p >= region_last(full)) nxt = '0;
    else                        nxt = edid_addr_t'(p + 1'b1);
    return nxt;
  endfunction

  // Processor may touch an address: always with software access, and
  // the upper half is free whenever the short region is selected.
  function automatic logic cpu_may_touch(input logic sw, input logic full,
                                         input edid_addr_t a);
    return sw || (!full && a[EDID_AW-1]);
  endfunction

  // Bit carried in data slot s (1..EDID_DW), most significant first.
  function automatic logic frame_bit(input edid_byte_t b, input slot_t s);
    logic r;
    r = 1'b1;
    for (int i = 0; i < EDID_DW; i++) begin
      if (s == slot_t'(EDID_DW - i)) r = b[i];
    end
    return r;
  endfunction

  // Slot that the next link clock edge opens.
  function automatic slot_t slot_after(input slot_t s);
    slot_t nxt;
    if (s >= slot_t'(FRAME_SLOTS)) nxt = slot_t'(1);
    else                           nxt = slot_t'(s + 1'b1);
    return nxt;
  endfunction

endpackage

// File: rtl/edid_vclk_sync.sv
module edid_vclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vclk_async,
  output logic vclk_rise
);

  logic [STAGES-1:0] chain_q;
  logic              hist_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= vclk_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= chain_q[STAGES-1];
  end

  assign vclk_rise = chain_q[STAGES-1] & ~hist_q;

endmodule

// File: rtl/edid_byte_buf.sv
module edid_byte_buf
  import edid_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_access,
  input  logic                size_full,
  input  logic                cpu_we,
  input  logic [EDID_AW-1:0]  cpu_addr,
  input  logic [EDID_DW-1:0]  cpu_wdata,
  output logic [EDID_DW-1:0]  cpu_rdata,
  input  logic [EDID_AW-1:0]  tx_addr,
  output logic [EDID_DW-1:0]  tx_byte
);

  localparam int unsigned DEPTH = 1 << EDID_AW;

  edid_byte_t mem_q [DEPTH];
  logic       cpu_ok;

  assign cpu_ok = cpu_may_touch(sw_access, size_full, cpu_addr);

  always_ff @(posedge clk) begin
    if (cpu_we && cpu_ok) mem_q[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_rdata <= '0;
    else if (cpu_ok) cpu_rdata <= mem_q[cpu_addr];
  end

  assign tx_byte = mem_q[tx_addr];

endmodule

// File: rtl/edid_tx_ptr.sv
module edid_tx_ptr
  import edid_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               size_full,
  input  logic               load,
  input  logic [EDID_AW-1:0] load_val,
  input  logic               step,
  output logic [EDID_AW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_advance(ptr, size_full);
  end

endmodule

// File: rtl/edid_frame_ctrl.sv
module edid_frame_ctrl
  import edid_tx_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic               vclk_rise,
  input  logic [EDID_DW-1:0] fetch_byte,
  output logic               fetch,
  output logic               in_sync,
  output logic               sda_o,
  output logic               sda_oe,
  output logic               byte_irq
);

  localparam int unsigned SC_W = $clog2(SYNC_CYCLES + 1);
  localparam logic [SC_W-1:0] SYNC_LAST = SC_W'(SYNC_CYCLES - 1);

  link_state_e     state_q;
  logic [SC_W-1:0] sync_cnt_q;
  slot_t           slot_q;
  slot_t           slot_nxt;
  edid_byte_t      byte_q;

  assign slot_nxt = slot_after(slot_q);
  assign fetch    = link_en && vclk_rise && (state_q == LNK_FRAMES)
                    && (slot_nxt == slot_t'(1));
  assign in_sync  = (state_q == LNK_PREAMBLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LNK_PREAMBLE;
      sync_cnt_q <= '0;
      slot_q     <= '0;
      byte_q     <= '0;
      sda_o      <= 1'b1;
      sda_oe     <= 1'b0;
      byte_irq   <= 1'b0;
    end else if (!link_en) begin
      state_q    <= LNK_PREAMBLE;
      sync_cnt_q <= '0;
      slot_q     <= '0;
      sda_o      <= 1'b1;
      sda_oe     <= 1'b0;
      byte_irq   <= 1'b0;
    end else begin
      byte_irq <= 1'b0;
      if (vclk_rise) begin
        case (state_q)
          LNK_PREAMBLE: begin
            if (sync_cnt_q == SYNC_LAST) begin
              state_q    <= LNK_FRAMES;
              sync_cnt_q <= '0;
            end else begin
              sync_cnt_q <= sync_cnt_q + 1'b1;
            end
          end
          LNK_FRAMES: begin
            slot_q <= slot_nxt;
            if (slot_nxt == slot_t'(1)) begin
              byte_q <= fetch_byte;
              sda_o  <= frame_bit(fetch_byte, slot_nxt);
              sda_oe <= 1'b1;
            end else if (slot_nxt <= slot_t'(EDID_DW)) begin
              sda_o  <= frame_bit(byte_q, slot_nxt);
              sda_oe <= 1'b1;
            end else begin
              sda_o    <= 1'b1;
              sda_oe   <= 1'b0;
              byte_irq <= 1'b1;
            end
          end
          default: state_q <= LNK_PREAMBLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/edid_serial_tx.sv
module edid_serial_tx
  import edid_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYNC_CYCLES = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vclk_in,
  input  logic               link_en,
  input  logic               sw_access,
  input  logic               size_full,
  input  logic               cpu_we,
  input  logic [EDID_AW-1:0] cpu_addr,
  input  logic [EDID_DW-1:0] cpu_wdata,
  output logic [EDID_DW-1:0] cpu_rdata,
  input  logic               ptr_we,
  input  logic [EDID_AW-1:0] ptr_wdata,
  output logic [EDID_AW-1:0] tx_ptr,
  output logic               sda_o,
  output logic               sda_oe,
  output logic               byte_irq
);

  logic       vclk_rise;
  logic       fetch;
  logic       in_sync;
  logic       ptr_load;
  edid_byte_t tx_byte;

  assign ptr_load = ptr_we & sw_access;

  edid_vclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .vclk_async (vclk_in),
    .vclk_rise  (vclk_rise)
  );

  edid_byte_buf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_access (sw_access),
    .size_full (size_full),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .tx_addr   (tx_ptr),
    .tx_byte   (tx_byte)
  );

  edid_tx_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_full (size_full),
    .load      (ptr_load),
    .load_val  (ptr_wdata),
    .step      (fetch),
    .ptr       (tx_ptr)
  );

  edid_frame_ctrl #(.SYNC_CYCLES(SYNC_CYCLES)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .vclk_rise  (vclk_rise),
    .fetch_byte (tx_byte),
    .fetch      (fetch),
    .in_sync    (in_sync),
    .sda_o      (sda_o),
    .sda_oe     (sda_oe),
    .byte_irq   (byte_irq)
  );

endmodule

// File: rtl/edid_serial_tx_chk.sv
module edid_serial_tx_chk
  import edid_tx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               link_en,
  input logic               size_full,
  input logic               vclk_rise,
  input logic               fetch,
  input logic               ptr_load,
  input logic               in_sync,
  input logic [EDID_AW-1:0] tx_ptr,
  input logic               sda_oe,
  input logic               byte_irq
);

  AST_PREAMBLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> !sda_oe); // R2

  AST_FETCH_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> sda_oe); // R3

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq); // R4

  AST_IRQ_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |-> !sda_oe); // R4

  AST_WRAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && !ptr_load && !size_full && (tx_ptr >= region_last(1'b0)) |=> (tx_ptr == '0)); // R5

  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && !ptr_load && size_full && (tx_ptr == region_last(1'b1)) |=> (tx_ptr == '0)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch && !ptr_load && (tx_ptr < region_last(size_full))
      |=> (tx_ptr == edid_addr_t'($past(tx_ptr) + 1'b1))); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch && !ptr_load |=> $stable(tx_ptr)); // R7

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> !sda_oe); // R9

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && !vclk_rise |=> $stable(sda_oe)); // R10

endmodule

bind edid_serial_tx edid_serial_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_en   (link_en),
  .size_full (size_full),
  .vclk_rise (vclk_rise),
  .fetch     (fetch),
  .ptr_load  (ptr_load),
  .in_sync   (in_sync),
  .tx_ptr    (tx_ptr),
  .sda_oe    (sda_oe),
  .byte_irq  (byte_irq)
);

// File: tb/edid_serial_tx_bench.sv
`timescale 1ns/1ps
module edid_serial_tx_bench;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk_in = 1'b0;
  logic       link_en = 1'b0;
  logic       sw_access = 1'b0;
  logic       size_full = 1'b0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       ptr_we = 1'b0;
  logic [7:0] ptr_wdata = '0;
  logic [7:0] tx_ptr;
  logic       sda_o;
  logic       sda_oe;
  logic       byte_irq;

  int nchk = 0;
  int nfail = 0;
  int irq_cnt = 0;
  int exp_ptr = 0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  edid_serial_tx u_edid_serial_tx (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .link_en(link_en),
    .sw_access(sw_access), .size_full(size_full), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .tx_ptr(tx_ptr),
    .sda_o(sda_o), .sda_oe(sda_oe), .byte_irq(byte_irq)
  );

  always @(posedge clk) if (byte_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pattern(input int a);
    return (a * 37 + 11) % 256;
  endfunction

  function automatic int after(input int a, input bit full);
    int last;
    last = full ? 255 : 127;
    return (a >= last) ? 0 : a + 1;
  endfunction

  task automatic write_byte(input int a, input int d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 8'(a); cpu_wdata = 8'(d);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic read_byte(input int a, output int d);
    @(negedge clk);
    cpu_addr = 8'(a);
    @(negedge clk);
    d = int'(cpu_rdata);
  endtask

  task automatic load_ptr(input int v);
    @(negedge clk);
    ptr_we = 1'b1; ptr_wdata = 8'(v);
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic vclk_high;
    @(negedge clk);
    vclk_in = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic vclk_low;
    vclk_in = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_preamble;
    for (int i = 0; i < 9; i++) begin
      int irq0;
      irq0 = irq_cnt;
      vclk_high;
      chk("R2 preamble released", int'(sda_oe), 0);
      chk("R2 preamble no irq", irq_cnt - irq0, 0);
      vclk_low;
    end
  endtask

  task automatic run_frames(input int n, input bit full);
    for (int f = 0; f < n; f++) begin
      int a;
      a = exp_ptr;
      for (int s = 1; s <= 9; s++) begin
        int irq0;
        irq0 = irq_cnt;
        vclk_high;
        if (s <= 8) begin
          chk("R3 drive enable", int'(sda_oe), 1);
          chk("R3 data bit", int'(sda_o), (int'(exp_mem[a]) >> (8 - s)) & 1);
          chk("R4 no irq in data slot", irq_cnt - irq0, 0);
        end else begin
          chk("R4 slot 9 released", int'(sda_oe), 0);
          chk("R4 one irq per frame", irq_cnt - irq0, 1);
        end
        if (s == 1) begin
          if (full) chk("R6 pointer after fetch", int'(tx_ptr), after(a, full));
          else      chk("R5 pointer after fetch", int'(tx_ptr), after(a, full));
        end
        vclk_low;
      end
      exp_ptr = after(a, full);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R1 reset byte_irq", int'(byte_irq), 0);
    chk("R1 reset tx_ptr", int'(tx_ptr), 0);
    chk("R1 reset cpu_rdata", int'(cpu_rdata), 0);

    // Fill the whole buffer with software access.
    sw_access = 1'b1; size_full = 1'b1;
    for (int a = 0; a < 256; a++) begin
      exp_mem[a] = 8'(pattern(a));
      write_byte(a, pattern(a));
    end
    read_byte(3, d);   chk("R8 readback with access", d, pattern(3));
    read_byte(250, d); chk("R8 readback with access", d, pattern(250));

    load_ptr(8'h10);
    chk("R7 pointer load with access", int'(tx_ptr), 16);
    sw_access = 1'b0;
    load_ptr(8'h33);
    chk("R8 pointer load blocked", int'(tx_ptr), 16);

    // Locked and open ranges.
    size_full = 1'b0;
    write_byte(5, 8'hAA);
    write_byte(200, 8'h55); exp_mem[200] = 8'h55;
    read_byte(200, d); chk("R8 upper half open in short mode", d, 8'h55);
    size_full = 1'b1;
    write_byte(201, 8'h66);
    sw_access = 1'b1;
    read_byte(5, d);   chk("R8 active write blocked", d, pattern(5));
    read_byte(201, d); chk("R8 full mode upper half locked", d, pattern(201));
    load_ptr(0);
    chk("R7 pointer load zero", int'(tx_ptr), 0);
    sw_access = 1'b0;

    // Short region: preamble, latency of one edge, disable mid-frame.
    size_full = 1'b0;
    @(negedge clk); link_en = 1'b1;
    run_preamble;
    @(negedge clk); vclk_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 no change after two edges", int'(sda_oe), 0);
    @(negedge clk);
    chk("R10 drive on third edge", int'(sda_oe), 1);
    chk("R10 first bit msb", int'(sda_o), (int'(exp_mem[0]) >> 7) & 1);
    chk("R7 pointer stepped once", int'(tx_ptr), 1);
    repeat (5) @(negedge clk);
    vclk_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 falling edge keeps enable", int'(sda_oe), 1);
    chk("R10 falling edge keeps pointer", int'(tx_ptr), 1);
    link_en = 1'b0;
    @(negedge clk);
    chk("R9 disable releases line", int'(sda_oe), 0);
    repeat (3) @(negedge clk);
    link_en = 1'b1;
    run_preamble;
    exp_ptr = 1;
    run_frames(130, 1'b0);

    // Full region from zero.
    @(negedge clk); link_en = 1'b0;
    sw_access = 1'b1;
    load_ptr(0);
    sw_access = 1'b0;
    size_full = 1'b1;
    @(negedge clk); link_en = 1'b1;
    run_preamble;
    exp_ptr = 0;
    run_frames(260, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule